// File: doc/BRIEF.md
# Multiplexer Residual-Variable Function Generator

This block realises any Boolean function of `NUM_VARS` inputs using a multiplexer with 2^(NUM_VARS-1) data legs instead of a full 2^NUM_VARS lookup table. The upper `NUM_VARS-1` input variables form the select index. The lowest variable is the *residue*. Each leg of the multiplexer takes one of four values: constant 0, constant 1, the residue, or the residue inverted. Per-leg choices are held in a configuration register.

Software-free setup uses a single write strobe with two loading styles. In direct mode the 2-bit leg codes are written as they are. In table mode a complete truth-table column is written, and the block folds each pair of rows into a leg code itself. The function output is purely combinational from the variable inputs. A new configuration applies from the clock edge that samples the strobe.

Top module: `mrf_func_gen`

## Requirements
- R1: `var_in[NUM_VARS-1:1]` is the binary index of the active leg. `var_in[NUM_VARS-1]` is its most significant bit, and leg k is held in configuration bits [2k+1:2k].
- R2: A leg holding code 2'b00 drives `f_out` to 0 whenever it is selected.
- R3: A leg holding code 2'b01 drives `f_out` to 1 whenever it is selected.
- R4: A leg holding code 2'b10 drives `f_out` equal to the residue `var_in[0]`.
- R5: A leg holding code 2'b11 drives `f_out` equal to the inverse of `var_in[0]`.
- R6: With `cfg_we`=1 and `cfg_mode`=0, `cfg_data` is stored as the leg codes at the next rising clock edge.
- R7: With `cfg_we`=1 and `cfg_mode`=1, `cfg_data` is treated as a truth table in which bit r is the output for `var_in`=r. Leg k is derived from bits 2k (residue 0) and 2k+1 (residue 1) as follows: the pair 0,0 gives code 00, 1,1 gives 01, 0,1 gives 10 and 1,0 gives 11. After the load, `f_out` equals `cfg_data[var_in]`.
- R8: While `rst_n` is low, and after it is released, every leg holds code 00 and `f_out` is 0 for every input.
- R9: Before the strobed edge the old configuration stays in force. Without `cfg_we`, changes on `cfg_data` and `cfg_mode` leave the function unchanged.
- R10: `f_out` follows `var_in` within the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 1 | 0 = leg codes, 1 = truth table |
| cfg_data | input | 2^NUM_VARS | Leg codes or truth-table column |
| var_in | input | NUM_VARS | Function variables; bit 0 is the residue |
| f_out | output | 1 | Function value |

## Verification
The bench attacks the places where a fold or a decode slip would show. The two mixed-row pairs are the first target: a design that swaps the pass and inverted codes in table mode gives the complement of the intended function on those legs. Walking a single constant-1 leg across every index exposes a reversed or shifted select, which would light the wrong input pattern. The bench also checks the output during the strobe cycle itself. A design that writes through at once would show the new function one cycle early, and a design that never takes writes would keep reporting zero. Random truth tables and random leg codes are each checked over all input combinations.

// File: rtl/mrf_pkg.sv
package mrf_pkg;

    typedef enum logic [1:0] {
        LEG_ZERO = 2'b00,
        LEG_ONE  = 2'b01,
        LEG_PASS = 2'b10,
        LEG_INV  = 2'b11
    } leg_code_e;

    // Reduce the two rows that differ only in the residue into a leg code.
    function automatic leg_code_e fold_rows(input logic row_r0, input logic row_r1);
        leg_code_e code;
        unique case ({row_r1, row_r0})
            2'b00:   code = LEG_ZERO;
            2'b11:   code = LEG_ONE;
            2'b10:   code = LEG_PASS;
            default: code = LEG_INV;
        endcase
        return code;
    endfunction

    // Value a leg presents for a given residue.
    function automatic logic leg_value(input leg_code_e code, input logic residue);
        logic v;
        unique case (code)
            LEG_ZERO: v = 1'b0;
            LEG_ONE:  v = 1'b1;
            LEG_PASS: v = residue;
            default:  v = ~residue;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/mrf_tt_fold.sv
module mrf_tt_fold #(
    parameter int NUM_VARS = 4
) (
    input  logic [(1<<NUM_VARS)-1:0]     tt_in,
    output logic [2*(1<<(NUM_VARS-1))-1:0] codes_out
);
    import mrf_pkg::*;

    localparam int LEGS = 1 << (NUM_VARS - 1);

    for (genvar k = 0; k < LEGS; k++) begin : g_pair
        always_comb begin
            codes_out[2*k +: 2] = fold_rows(tt_in[2*k], tt_in[2*k+1]);
        end
    end

endmodule

// File: rtl/mrf_cfg_reg.sv
module mrf_cfg_reg #(
    parameter int NUM_VARS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic                          mode_table,
    input  logic [2*(1<<(NUM_VARS-1))-1:0] direct_codes,
    input  logic [2*(1<<(NUM_VARS-1))-1:0] folded_codes,
    output logic [2*(1<<(NUM_VARS-1))-1:0] codes_q
);
    localparam int LEGS   = 1 << (NUM_VARS - 1);
    localparam int CODE_W = 2 * LEGS;

    typedef struct packed {
        logic [CODE_W-1:0] codes;
    } cfg_state_t;

    cfg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (we) begin
            state_d.codes = mode_table ? folded_codes : direct_codes;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign codes_q = state_q.codes;

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> codes_q == '0); // R8
    AST_HOLD_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(codes_q)); // R9
    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we && !mode_table |=> codes_q == $past(direct_codes)); // R6
    AST_TABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we && mode_table |=> codes_q == $past(folded_codes)); // R7

endmodule

// File: rtl/mrf_leg_eval.sv
module mrf_leg_eval #(
    parameter int NUM_VARS = 4
) (
    input  logic [2*(1<<(NUM_VARS-1))-1:0] codes,
    input  logic                          residue,
    output logic [(1<<(NUM_VARS-1))-1:0]   leg_vals
);
    import mrf_pkg::*;

    localparam int LEGS = 1 << (NUM_VARS - 1);

    for (genvar k = 0; k < LEGS; k++) begin : g_leg
        always_comb begin
            leg_vals[k] = leg_value(leg_code_e'(codes[2*k +: 2]), residue);
        end
    end

endmodule

// File: rtl/mrf_sel_mux.sv
module mrf_sel_mux #(
    parameter int NUM_VARS = 4
) (
    input  logic [(1<<(NUM_VARS-1))-1:0] leg_vals,
    input  logic [NUM_VARS-2:0]          sel,
    output logic                         y
);
    localparam int SEL_W = NUM_VARS - 1;
    localparam int LEGS  = 1 << SEL_W;

    // Binary tree of 2:1 stages; stage s is steered by select bit s.
    logic [2*LEGS-2:0] node;

    for (genvar i = 0; i < LEGS; i++) begin : g_leaf
        assign node[LEGS-1+i] = leg_vals[i];
    end

    for (genvar lvl = 0; lvl < SEL_W; lvl++) begin : g_lvl
        localparam int FIRST = (1 << lvl) - 1;
        localparam int CNT   = 1 << lvl;
        for (genvar j = 0; j < CNT; j++) begin : g_node
            assign node[FIRST+j] = sel[SEL_W-1-lvl]
                ? node[2*(FIRST+j)+2] : node[2*(FIRST+j)+1];
        end
    end

    assign y = node[0];

endmodule

// File: rtl/mrf_func_gen.sv
module mrf_func_gen #(
    parameter int NUM_VARS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic                        cfg_mode,
    input  logic [(1<<NUM_VARS)-1:0]    cfg_data,
    input  logic [NUM_VARS-1:0]         var_in,
    output logic                        f_out
);
    localparam int SEL_W  = NUM_VARS - 1;
    localparam int LEGS   = 1 << SEL_W;
    localparam int CODE_W = 2 * LEGS;
    localparam int TT_W   = 1 << NUM_VARS;

    logic [CODE_W-1:0] folded;
    logic [CODE_W-1:0] codes_q;
    logic [LEGS-1:0]   leg_vals;
    logic [1:0]        active_code;

    mrf_tt_fold #(.NUM_VARS(NUM_VARS)) u_fold (
        .tt_in     (cfg_data),
        .codes_out (folded)
    );

    mrf_cfg_reg #(.NUM_VARS(NUM_VARS)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .we           (cfg_we),
        .mode_table   (cfg_mode),
        .direct_codes (cfg_data),
        .folded_codes (folded),
        .codes_q      (codes_q)
    );

    mrf_leg_eval #(.NUM_VARS(NUM_VARS)) u_legs (
        .codes    (codes_q),
        .residue  (var_in[0]),
        .leg_vals (leg_vals)
    );

    mrf_sel_mux #(.NUM_VARS(NUM_VARS)) u_mux (
        .leg_vals (leg_vals),
        .sel      (var_in[NUM_VARS-1:1]),
        .y        (f_out)
    );

    assign active_code = codes_q[2*var_in[NUM_VARS-1:1] +: 2];

    AST_ZERO_LEG: assert property (@(posedge clk) disable iff (!rst_n)
        active_code == 2'b00 |-> !f_out); // R2
    AST_ONE_LEG: assert property (@(posedge clk) disable iff (!rst_n)
        active_code == 2'b01 |-> f_out); // R3
    AST_PASS_LEG: assert property (@(posedge clk) disable iff (!rst_n)
        active_code == 2'b10 |-> f_out == var_in[0]); // R4
    AST_INV_LEG: assert property (@(posedge clk) disable iff (!rst_n)
        active_code == 2'b11 |-> f_out != var_in[0]); // R5
    AST_TABLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_mode |=>
        {{(TT_W-1){1'b0}}, f_out} == (($past(cfg_data) >> var_in) & TT_W'(1))); // R7

endmodule

// File: tb/mrf_func_gen_tb.sv
`timescale 1ns/1ps
module mrf_func_gen_tb;
    localparam int N    = 4;
    localparam int LEGS = 1 << (N - 1);
    localparam int TT_W = 1 << N;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic            cfg_mode = 1'b0;
    logic [TT_W-1:0] cfg_data = '0;
    logic [N-1:0]    var_in = '0;
    logic            f_out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [TT_W-1:0] exp_codes = '0;

    always #4 clk = ~clk;

    mrf_func_gen #(.NUM_VARS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_data(cfg_data), .var_in(var_in), .f_out(f_out)
    );

    function automatic logic ref_out(input logic [TT_W-1:0] codes, input logic [N-1:0] v);
        logic [1:0] c;
        c = codes[2*int'(v[N-1:1]) +: 2];
        case (c)
            2'b00:   return 1'b0;
            2'b01:   return 1'b1;
            2'b10:   return v[0];
            default: return ~v[0];
        endcase
    endfunction

    function automatic logic [TT_W-1:0] ref_fold(input logic [TT_W-1:0] tt);
        logic [TT_W-1:0] r;
        r = '0;
        for (int k = 0; k < LEGS; k++) begin
            case ({tt[2*k], tt[2*k+1]})
                2'b00:   r[2*k +: 2] = 2'b00;
                2'b11:   r[2*k +: 2] = 2'b01;
                2'b01:   r[2*k +: 2] = 2'b10;
                default: r[2*k +: 2] = 2'b11;
            endcase
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s var_in=%0d actual=%b expected=%b", tag, var_in, act, exp);
        end
    endtask

    // Sweep all inputs combinationally (R10: no clock between drive and sample).
    task automatic sweep(input string tag);
        for (int v = 0; v < TT_W; v++) begin
            var_in = N'(v);
            #0.5;
            check(tag, f_out, ref_out(exp_codes, N'(v)));
        end
    endtask

    task automatic write_cfg(input logic mode, input logic [TT_W-1:0] data, input string tag);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = mode; cfg_data = data;
        var_in = N'($urandom_range(TT_W-1));
        #1;
        check("R9 old config during strobe", f_out, ref_out(exp_codes, var_in));
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        exp_codes = mode ? ref_fold(data) : data;
        cfg_data = ~data;
        sweep(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [TT_W-1:0] tt;
        void'($urandom(32'd20240611));
        #2;
        sweep("R8 during reset");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        sweep("R8 after reset");

        write_cfg(1'b0, {LEGS{2'b00}}, "R2 all zero legs");
        write_cfg(1'b0, {LEGS{2'b01}}, "R3 all one legs");
        write_cfg(1'b0, {LEGS{2'b10}}, "R4 all pass legs");
        write_cfg(1'b0, {LEGS{2'b11}}, "R5 all inverted legs");
        for (int k = 0; k < LEGS; k++) begin
            write_cfg(1'b0, TT_W'(2'b01) << (2*k), "R1 walking one leg");
        end
        write_cfg(1'b0, 16'b01_00_11_10_01_00_10_11, "R6 mixed codes");

        // Truth table mixing all four row-pair patterns (R7).
        write_cfg(1'b1, 16'b11_00_01_10_11_00_01_10, "R7 fold patterns");
        for (int v = 0; v < TT_W; v++) begin
            var_in = N'(v);
            #0.5;
            check("R7 table bit", f_out, tt_bit(16'b11_00_01_10_11_00_01_10, v));
        end

        // No strobe: data and mode change, function must not (R9).
        @(negedge clk);
        cfg_data = 16'hFFFF; cfg_mode = 1'b0;
        repeat (3) @(negedge clk);
        cfg_mode = 1'b1; cfg_data = 16'h0000;
        repeat (2) @(negedge clk);
        sweep("R9 hold without strobe");

        for (int i = 0; i < 300; i++) begin
            tt = TT_W'($urandom);
            if ($urandom_range(1) == 1) begin
                write_cfg(1'b1, tt, "R7 random table");
                for (int v = 0; v < TT_W; v++) begin
                    var_in = N'(v);
                    #0.5;
                    check("R7 random table bit", f_out, tt[v]);
                end
            end else begin
                write_cfg(1'b0, tt, "R6 random codes");
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    function automatic logic tt_bit(input logic [TT_W-1:0] tt, input int idx);
        return tt[idx];
    endfunction

endmodule